// File: doc/BRIEF.md
# Multi-Bus I2C Interrupt Aggregator

This block gathers interrupt events from a set of I2C bus engines and exposes them to a host through a small register space. Each bus has a 15-bit event status register and a 15-bit enable register. A bus engine posts events as a one-cycle pulse with a bit vector. At that moment the bus status keeps only the bits that its enable register allows. A status bit that is disabled is removed from status, not just hidden from the line.

When a posted event leaves any status bit standing, the block sets that bus's bit in a controller-wide summary register and raises one shared interrupt line. The host clears events by writing ones to the bus status register. Any such write also drops that bus's summary bit and lowers the shared line in the same step, even when other buses still hold events. The host then reads the summary to find out which buses still need service.

All registers sit in one 4 KB region. The summary is at the bottom of the region and each bus has its own 64-byte window. The number of buses is a parameter, up to 14.

Top module: `i2c_irq_agg`

## Requirements
- R1: A synchronous reset clears every enable register, every status register, the summary register and the interrupt line.
- R2: When `evt_valid[b]` is high, bus b status becomes (status OR `evt_bits` slice b) AND the enable register of bus b as it was before that edge. Disabled bits are dropped, including ones that were already held. Status bit positions are fixed: 0 transmit acknowledged, 1 transmit not acknowledged, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal condition, 6 clock-line timeout, up to 14 data-line timeout.
- R3: A post whose masked result is nonzero sets summary bit b and the interrupt line at the sampling edge. A post whose masked result is zero sets neither, and nothing but a post sets them.
- R4: A write to a bus status register clears each status bit written as one in bits 14:0. The same write clears that bus's summary bit and lowers the interrupt line, whatever other buses hold.
- R5: A write to a bus enable register keeps bits 14:0 of the data. Reads return those bits with the upper bits zero.
- R6: The summary register is at offset 0x000. Bit b belongs to bus b and the upper bits read zero. The register is read-only, and writes to it change nothing.
- R7: Bus b has its window at 0x40*(b+1) for b below 7 and at 0x40*(b+5) otherwise. Enable is at window offset 0x0C and status at 0x10.
- R8: Reads from any other offset return 0xFFFFFFFF, and writes to any other offset change no register.
- R9: When a status write and a post to the same bus land on one edge, the clear is applied first and the masked post second. A summary or line set from any post takes precedence over a clear in that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | Host access is a write |
| req_addr | input | 12 | Byte offset within the region |
| req_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Read data for `req_addr`, combinational |
| evt_valid | input | NUM_BUS | Per-bus event post strobe |
| evt_bits | input | NUM_BUS*15 | Per-bus event vectors, bus b in slice b |
| irq | output | 1 | Shared interrupt line |

## Verification
Host writes and event posts are both captured at the rising edge where they are presented. The new register contents and the interrupt line are therefore valid one edge later. Read data follows `req_addr` with no register in between, so a read shows state at the cycle in which the address is applied. The bench changes inputs only on the falling edge and samples every result on a later falling edge. That way each check falls after the capturing rising edge and before the next one. The same-edge case of R9 presents the clear and the post in one falling-edge window so that both meet the same rising edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int STAT_W    = 15;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int WIN_W     = 6;
    localparam int MAX_BUS   = 14;
    localparam int LOW_WINS  = 7;

    localparam logic [WIN_W-1:0] OFS_ENABLE = 6'h0C;
    localparam logic [WIN_W-1:0] OFS_STATUS = 6'h10;

    // status bit positions
    localparam int EV_TX_ACK   = 0;
    localparam int EV_TX_NAK   = 1;
    localparam int EV_RX_DONE  = 2;
    localparam int EV_ARB_LOST = 3;
    localparam int EV_STOP     = 4;
    localparam int EV_ABNORMAL = 5;
    localparam int EV_SCL_TMO  = 6;
    localparam int EV_SDA_TMO  = 14;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_SUMMARY,
        REG_ENABLE,
        REG_STATUS
    } reg_kind_e;

    // window number (addr[11:6]) holding bus idx
    function automatic logic [WIN_W-1:0] bus_window(input int idx);
        return (idx < LOW_WINS) ? WIN_W'(idx + 1) : WIN_W'(idx + 5);
    endfunction

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUS = 14,
    localparam int IDX_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  bus_idx
);

    logic [WIN_W-1:0] window;
    logic [WIN_W-1:0] offset;

    assign window = addr[ADDR_W-1:WIN_W];
    assign offset = addr[WIN_W-1:0];

    always_comb begin
        kind    = REG_NONE;
        bus_idx = '0;
        if (addr == '0) begin
            kind = REG_SUMMARY;
        end
        for (int b = 0; b < NUM_BUS; b++) begin
            if (window == bus_window(b)) begin
                bus_idx = IDX_W'(b);
                if (offset == OFS_ENABLE) begin
                    kind = REG_ENABLE;
                end else if (offset == OFS_STATUS) begin
                    kind = REG_STATUS;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_irq_slot.sv
module i2c_irq_slot
    import i2c_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_wr,
    input  logic  st_wr,
    input  stat_t wdata,
    input  logic  evt_valid,
    input  stat_t evt_bits,
    output stat_t en_q,
    output stat_t st_q,
    output logic  sum_q,
    output logic  raise
);

    stat_t cleared;
    stat_t posted;
    stat_t st_d;

    // clear first, then the masked post against the enable held before this edge
    always_comb begin
        cleared = st_wr ? (st_q & ~wdata) : st_q;
        posted  = (cleared | evt_bits) & en_q;
        st_d    = evt_valid ? posted : cleared;
        raise   = evt_valid && (posted != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            st_q  <= '0;
            sum_q <= 1'b0;
        end else begin
            if (en_wr) begin
                en_q <= wdata;
            end
            st_q <= st_d;
            if (raise) begin
                sum_q <= 1'b1;
            end else if (st_wr) begin
                sum_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUS = 14
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [NUM_BUS-1:0]        evt_valid,
    input  logic [NUM_BUS*STAT_W-1:0] evt_bits,
    output logic                      irq
);

    localparam int IDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    reg_kind_e                 kind;
    logic [IDX_W-1:0]          bus_idx;
    logic                      wr;
    logic [NUM_BUS-1:0]        en_wr;
    logic [NUM_BUS-1:0]        st_wr;
    logic [NUM_BUS-1:0]        raise;
    logic [NUM_BUS-1:0]        summary;
    logic [NUM_BUS*STAT_W-1:0] en_flat;
    logic [NUM_BUS*STAT_W-1:0] stat_flat;
    logic                      stat_wr_any;
    logic                      unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[DATA_W-1:STAT_W];

    i2c_irq_decode #(.NUM_BUS(NUM_BUS)) u_decode (
        .addr    (req_addr),
        .kind    (kind),
        .bus_idx (bus_idx)
    );

    assign wr = req_valid && req_write;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_slot
        assign en_wr[b] = wr && (kind == REG_ENABLE) && (bus_idx == IDX_W'(b));
        assign st_wr[b] = wr && (kind == REG_STATUS) && (bus_idx == IDX_W'(b));

        i2c_irq_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .en_wr     (en_wr[b]),
            .st_wr     (st_wr[b]),
            .wdata     (req_wdata[STAT_W-1:0]),
            .evt_valid (evt_valid[b]),
            .evt_bits  (evt_bits[b*STAT_W +: STAT_W]),
            .en_q      (en_flat[b*STAT_W +: STAT_W]),
            .st_q      (stat_flat[b*STAT_W +: STAT_W]),
            .sum_q     (summary[b]),
            .raise     (raise[b])
        );
    end

    assign stat_wr_any = |st_wr;

    // shared line: any raise wins over any clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (|raise) begin
            irq <= 1'b1;
        end else if (stat_wr_any) begin
            irq <= 1'b0;
        end
    end

    always_comb begin
        stat_t sel_en;
        stat_t sel_st;
        sel_en = '0;
        sel_st = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (bus_idx == IDX_W'(b)) begin
                sel_en = en_flat[b*STAT_W +: STAT_W];
                sel_st = stat_flat[b*STAT_W +: STAT_W];
            end
        end
        unique case (kind)
            REG_SUMMARY: rd_data = DATA_W'(summary);
            REG_ENABLE:  rd_data = DATA_W'(sel_en);
            REG_STATUS:  rd_data = DATA_W'(sel_st);
            default:     rd_data = '1;
        endcase
    end

endmodule

// File: rtl/i2c_irq_agg_chk.sv
module i2c_irq_agg_chk
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUS = 14
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic [NUM_BUS-1:0]        evt_valid,
    input logic [NUM_BUS-1:0]        summary,
    input logic                      irq,
    input logic [NUM_BUS*STAT_W-1:0] stat_flat,
    input logic [NUM_BUS*STAT_W-1:0] en_flat,
    input logic                      stat_wr_any
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (summary == '0 && !irq));

    assert_masked_post_R2: assert property (@(posedge clk) disable iff (rst)
        (stat_flat & ~$past(stat_flat) & ~$past(en_flat)) == '0);

    assert_irq_needs_event_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_valid != '0));

    assert_summary_needs_event_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid == '0) |=> ((summary & ~$past(summary)) == '0));

    assert_clear_drops_line_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_any && evt_valid == '0) |=> !irq);

    assert_summary_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == '0 && evt_valid == '0) |=> $stable(summary));

endmodule

bind i2c_irq_agg i2c_irq_agg_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .evt_valid   (evt_valid),
    .summary     (summary),
    .irq         (irq),
    .stat_flat   (stat_flat),
    .en_flat     (en_flat),
    .stat_wr_any (stat_wr_any)
);

// File: tb/i2c_irq_agg_tb.sv
module i2c_irq_agg_tb;
    import i2c_irq_pkg::*;

    localparam int NB = 14;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic [DATA_W-1:0]    rd_data;
    logic [NB-1:0]        evt_valid = '0;
    logic [NB*STAT_W-1:0] evt_bits = '0;
    logic                 irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    i2c_irq_agg #(.NUM_BUS(NB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .evt_valid (evt_valid),
        .evt_bits  (evt_bits),
        .irq       (irq)
    );

    function automatic logic [ADDR_W-1:0] base(input int b);
        return (b < 7) ? ADDR_W'(64 * (b + 1)) : ADDR_W'(64 * (b + 5));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        evt_valid = '0;
        evt_bits  = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_addr = a;
        #2;
        d = rd_data;
    endtask

    task automatic post(input int b, input logic [STAT_W-1:0] bits);
        @(negedge clk);
        evt_valid[b] = 1'b1;
        evt_bits[b*STAT_W +: STAT_W] = bits;
        @(negedge clk);
        evt_valid = '0;
        evt_bits  = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(12'h000, d);  check("R1 summary after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(base(0) + 12'h0C, d); check("R1 enable after reset", d, 32'h0);
        rd(base(13) + 12'h10, d); check("R1 status after reset", d, 32'h0);
    endtask

    task automatic t_enable_width();
        logic [31:0] d;
        do_reset();
        wr(base(0) + 12'h0C, 32'hFFFF_FFFF);
        rd(base(0) + 12'h0C, d); check("R5 enable keeps 14:0", d, 32'h0000_7FFF);
    endtask

    task automatic t_post_and_clear();
        logic [31:0] d;
        do_reset();
        wr(base(0) + 12'h0C, 32'h15);
        post(0, 15'h00FF);
        rd(base(0) + 12'h10, d); check("R2 masked post", d, 32'h15);
        rd(12'h000, d);          check("R3 summary set", d, 32'h1);
        check("R3 irq raised", {31'b0, irq}, 32'h1);
        wr(base(0) + 12'h10, 32'h4);
        rd(base(0) + 12'h10, d); check("R4 w1c clears bit 2", d, 32'h11);
        rd(12'h000, d);          check("R4 summary cleared", d, 32'h0);
        check("R4 irq lowered", {31'b0, irq}, 32'h0);
        wr(base(0) + 12'h0C, 32'h1);
        post(0, 15'h0);
        rd(base(0) + 12'h10, d); check("R2 held disabled bit dropped", d, 32'h1);
        check("R3 irq from surviving bit", {31'b0, irq}, 32'h1);
        wr(base(0) + 12'h10, 32'hFFFF_FFFF);
        rd(base(0) + 12'h10, d); check("R4 clear all", d, 32'h0);
    endtask

    task automatic t_disabled_only();
        logic [31:0] d;
        do_reset();
        post(3, 15'h7FFF);
        rd(base(3) + 12'h10, d); check("R2 disabled post discarded", d, 32'h0);
        rd(12'h000, d);          check("R3 no summary for empty post", d, 32'h0);
        check("R3 no irq for empty post", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_shared_line();
        logic [31:0] d;
        do_reset();
        wr(base(2) + 12'h0C, 32'h7FFF);
        wr(base(9) + 12'h0C, 32'h7FFF);
        post(2, 15'h3);
        post(9, 15'h1 << EV_STOP);
        rd(12'h000, d); check("R3 two summary bits", d, 32'h204);
        wr(base(2) + 12'h10, 32'h0);
        rd(12'h000, d); check("R4 only bus 2 summary dropped", d, 32'h200);
        check("R4 line lowered despite bus 9", {31'b0, irq}, 32'h0);
        rd(base(2) + 12'h10, d); check("R4 zero write keeps status", d, 32'h3);
        rd(base(9) + 12'h10, d); check("R4 other bus status kept", d, 32'h10);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); check("R6 summary write ignored", d, 32'h200);
        check("R6 summary write leaves irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        do_reset();
        wr(base(13) + 12'h0C, 32'h1234);
        rd(12'h48C, d); check("R7 bus 13 enable at 0x48C", d, 32'h1234);
        wr(12'h30C, 32'h4000);
        rd(base(7) + 12'h0C, d); check("R7 bus 7 enable at 0x30C", d, 32'h4000);
        wr(12'h04C, 32'h0001);
        rd(base(0) + 12'h0C, d); check("R7 bus 0 enable at 0x04C", d, 32'h1);
        post(7, 15'h1 << EV_SDA_TMO);
        rd(12'h310, d); check("R7 bus 7 status at 0x310", d, 32'h4000);
        rd(12'h000, d); check("R7 summary bit 7", d, 32'h80);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        do_reset();
        wr(12'h20C, 32'h7FFF);
        wr(12'h004, 32'h7FFF);
        wr(base(0) + 12'h14, 32'h7FFF);
        for (int b = 0; b < NB; b++) begin
            rd(base(b) + 12'h0C, d);
            check("R8 stray write leaves enables", d, 32'h0);
        end
        rd(12'h20C, d); check("R8 gap window reads ones", d, 32'hFFFF_FFFF);
        rd(12'h004, d); check("R8 summary window other offset", d, 32'hFFFF_FFFF);
        rd(base(0) + 12'h04, d); check("R8 bus window other offset", d, 32'hFFFF_FFFF);
        rd(12'h4CC, d); check("R8 past last bus", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_edge();
        logic [31:0] d;
        do_reset();
        wr(base(5) + 12'h0C, 32'h7FFF);
        post(5, 15'h1 << EV_TX_NAK);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = base(5) + 12'h10;
        req_wdata = 32'h2;
        evt_valid[5] = 1'b1;
        evt_bits[5*STAT_W +: STAT_W] = 15'h1 << EV_ARB_LOST;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        evt_valid = '0;
        evt_bits  = '0;
        check("R9 set wins on irq", {31'b0, irq}, 32'h1);
        rd(base(5) + 12'h10, d); check("R9 clear then post", d, 32'h8);
        rd(12'h000, d);          check("R9 set wins on summary", d, 32'h20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_width();
        t_post_and_clear();
        t_disabled_only();
        t_shared_line();
        t_map();
        t_unmapped();
        t_same_edge();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule